// File: doc/BRIEF.md
# Request/Go-Ahead SPI Bus Arbiter

This block sits at the centre of a star of attached components. Each component acts as an SPI controller and drives its own clock and data lines. The block acts as the one shared SPI peripheral. A component asks for service by pulling its active-low request line low. The arbiter chooses one requester at a time and pulls that port's active-low go-ahead line low. It then routes the port's clock and data into a single internal mode-0 shift engine. On the core side, that engine delivers each received byte with a one-cycle valid strobe and the port number. It also fetches the reply bytes from a byte input.

A component that finishes normally releases its request while its go-ahead is still low, and the transfer counts as accepted. The arbiter can also hang up by releasing go-ahead early. It does this when a programmable grant-length limit runs out, which sets a per-port timeout flag, or when the core raises the abort input. Ports that are waiting are served round-robin. A port that was served must show its request high before it can be granted again.

Top module: `spi_arb_hub`

## Requirements
- R1: At most one go-ahead output is low at any time. An idle arbiter pulls a lone requester's go-ahead low on the third clock edge after its request falls, because of two synchroniser stages and one grant register.
- R2: Among the waiting ports, the grant goes to the first one found by counting upward, with wrap-around, from the port after the last one granted. After reset, port 0 is searched first.
- R3: When a granted port releases its request before the limit or an abort, the transfer is accepted. Go-ahead stays low for two more clock edges after the request rises and goes high on the third.
- R4: If the request is held, go-ahead stays low for exactly grant_limit+1 clock cycles. It is then released, and that port's timeout flag is set. The flag stays set until the same port is granted again.
- R5: An abort sampled high during a grant releases go-ahead at that clock edge and leaves every timeout flag unchanged.
- R6: A port whose grant ended by timeout or abort is not granted again while its request stays low. It becomes eligible only after its request has been seen high.
- R7: Data from the granted port is sampled on rising SCK, MSB first. After the eighth rising edge of each byte, rx_valid pulses for one cycle, carrying the byte on rx_data and the port number on rx_port.
- R8: tx_data is captured at the grant and again on the first falling SCK edge after each completed byte, and each capture pulses tx_take. The captured byte appears on the granted port's CIPO MSB first: the first bit is present before the first rising edge, and each following bit appears after each falling edge.
- R9: CIPO of every port that is not granted is driven 0.
- R10: After reset, every go-ahead is high, every CIPO and timeout flag is 0, and rx_valid and tx_take are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grant_limit | input | TW | Grant length limit in cycles, minus one |
| abort | input | 1 | Core request to hang up on the current grant |
| req_n | input | NPORT | Active-low request, one per port |
| sck | input | NPORT | SPI clock from each component |
| copi | input | NPORT | Controller-out data from each component |
| cipo | output | NPORT | Peripheral-out data to each component |
| gnt_n | output | NPORT | Active-low go-ahead, one per port |
| to_flag | output | NPORT | Per-port timeout flag |
| tx_data | input | 8 | Next reply byte from the core |
| tx_take | output | 1 | Pulse: tx_data was captured |
| rx_valid | output | 1 | Pulse: a complete byte was received |
| rx_data | output | 8 | Received byte |
| rx_port | output | PW | Port that sent rx_data |

## Verification
A corrupted last-granted pointer shows up as a wrong go-ahead within three cycles of the next set of requests. The round-robin sweep walks every request mask to expose it. A stuck eligibility bit appears either as an immediate re-grant after a timeout or as a port that is never served, and the hold-after-hang-up checks look for both. A wrong bit counter or shift register misplaces data within one byte, which appears as a mismatch on rx_data or on the CIPO bits the component samples. A grant timer that is off by one changes the measured go-ahead low time by one cycle.

// File: rtl/spi_arb_pkg.sv
package spi_arb_pkg;
  typedef enum logic {ST_IDLE, ST_BUSY} arb_state_e;

  // next index after idx, wrapping at n
  function automatic int unsigned wrap_inc(int unsigned idx, int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // position of the k-th candidate when scanning from after 'last'
  function automatic int unsigned scan_pos(int unsigned last, int unsigned k,
                                           int unsigned n);
    return (last + k) % n;
  endfunction
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/arb_rr.sv
module arb_rr
  import spi_arb_pkg::*;
#(
  parameter int N  = 4,
  parameter int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  elig,
  input  logic [PW-1:0] last,
  output logic          found,
  output logic [PW-1:0] pick
);
  // scan from the farthest offset down so the nearest eligible wins
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = N; k >= 1; k--) begin
      int unsigned idx;
      idx = scan_pos(int'(last), k, N);
      if (elig[idx]) begin
        found = 1'b1;
        pick  = PW'(idx);
      end
    end
  end
endmodule

// File: rtl/arb_spi_peri.sv
module arb_spi_peri #(
  parameter int BW = 8,
  parameter int CW = $clog2(BW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          active,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          copi_bit,
  input  logic [BW-1:0] tx_data,
  output logic          miso,
  output logic          tx_take,
  output logic          rx_valid,
  output logic [BW-1:0] rx_data
);
  localparam logic [CW-1:0] LAST_BIT = CW'(BW - 1);

  logic [BW-1:0] tx_sh;
  logic [BW-2:0] rx_sh;
  logic [CW-1:0] bitcnt;
  logic          at_boundary;

  assign at_boundary = (bitcnt == '0);
  assign miso        = tx_sh[BW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh    <= '0;
      rx_sh    <= '0;
      bitcnt   <= '0;
      tx_take  <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      tx_take  <= 1'b0;
      rx_valid <= 1'b0;
      if (start) begin
        tx_sh   <= tx_data;
        bitcnt  <= '0;
        tx_take <= 1'b1;
      end else if (active) begin
        if (sck_rise) begin
          rx_sh  <= {rx_sh[BW-3:0], copi_bit};
          bitcnt <= (bitcnt == LAST_BIT) ? '0 : bitcnt + 1'b1;
          if (bitcnt == LAST_BIT) begin
            rx_valid <= 1'b1;
            rx_data  <= {rx_sh, copi_bit};
          end
        end else if (sck_fall) begin
          if (at_boundary) begin
            tx_sh   <= tx_data;
            tx_take <= 1'b1;
          end else begin
            tx_sh <= {tx_sh[BW-2:0], 1'b0};
          end
        end
      end
    end
  end

  // R7: a byte needs eight separate rising edges, so strobes never touch
  p_rx_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R8: a capture is never followed by another capture on the next cycle
  p_take_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> !tx_take);
endmodule

// File: rtl/spi_arb_hub.sv
module spi_arb_hub
  import spi_arb_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int TW    = 16,
  localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    grant_limit,
  input  logic             abort,
  input  logic [NPORT-1:0] req_n,
  input  logic [NPORT-1:0] sck,
  input  logic [NPORT-1:0] copi,
  output logic [NPORT-1:0] cipo,
  output logic [NPORT-1:0] gnt_n,
  output logic [NPORT-1:0] to_flag,
  input  logic [7:0]       tx_data,
  output logic             tx_take,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic [PW-1:0]    rx_port
);
  localparam logic [PW-1:0] LAST_RESET = PW'(NPORT - 1);

  // synchronised port inputs
  logic [NPORT-1:0] req_s, sck_s, copi_s;

  arb_sync #(.W(NPORT), .RST_VAL({NPORT{1'b1}})) u_sync_req (
    .clk(clk), .rst_n(rst_n), .d(req_n), .q(req_s));
  arb_sync #(.W(NPORT), .RST_VAL({NPORT{1'b0}})) u_sync_sck (
    .clk(clk), .rst_n(rst_n), .d(sck), .q(sck_s));
  arb_sync #(.W(NPORT), .RST_VAL({NPORT{1'b0}})) u_sync_copi (
    .clk(clk), .rst_n(rst_n), .d(copi), .q(copi_s));

  // arbitration state
  arb_state_e       state;
  logic [PW-1:0]    cur, last;
  logic [TW-1:0]    cnt;
  logic [NPORT-1:0] armed;
  logic             busy;

  // named events
  logic [NPORT-1:0] elig;
  logic             found;
  logic [PW-1:0]    pick;
  logic             grant_evt, rel_evt, to_hit, abort_hit, end_evt;
  logic [NPORT-1:0] pick_mask, cur_mask;

  assign busy = (state == ST_BUSY);
  assign elig = ~req_s & armed;

  arb_rr #(.N(NPORT), .PW(PW)) u_rr (
    .elig(elig), .last(last), .found(found), .pick(pick));

  always_comb begin
    pick_mask = '0;
    cur_mask  = '0;
    pick_mask[pick] = 1'b1;
    cur_mask[cur]   = 1'b1;
  end

  assign grant_evt = !busy && found;
  assign rel_evt   = busy && req_s[cur];
  assign to_hit    = busy && !rel_evt && (cnt == grant_limit);
  assign abort_hit = busy && !rel_evt && !to_hit && abort;
  assign end_evt   = rel_evt || to_hit || abort_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cur     <= '0;
      last    <= LAST_RESET;
      cnt     <= '0;
      armed   <= '1;
      to_flag <= '0;
    end else begin
      armed <= (armed | req_s) & ~(grant_evt ? pick_mask : '0);
      if (grant_evt) begin
        state   <= ST_BUSY;
        cur     <= pick;
        last    <= pick;
        cnt     <= '0;
        to_flag <= to_flag & ~pick_mask;
      end else if (busy) begin
        if (end_evt) begin
          state <= ST_IDLE;
          if (to_hit) to_flag <= to_flag | cur_mask;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign gnt_n = busy ? ~cur_mask : '1;

  // SPI routing and edge detection
  logic sck_sel, sck_q, copi_sel, sck_rise, sck_fall, miso;

  assign sck_sel  = sck_s[cur];
  assign copi_sel = copi_s[cur];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sck_q <= 1'b0;
    else if (grant_evt) sck_q <= sck_s[pick];
    else                sck_q <= sck_sel;
  end

  assign sck_rise = busy && sck_sel && !sck_q;
  assign sck_fall = busy && !sck_sel && sck_q;

  arb_spi_peri #(.BW(8)) u_peri (
    .clk(clk), .rst_n(rst_n), .start(grant_evt), .active(busy),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .copi_bit(copi_sel),
    .tx_data(tx_data), .miso(miso), .tx_take(tx_take),
    .rx_valid(rx_valid), .rx_data(rx_data));

  assign rx_port = cur;
  assign cipo    = busy ? (cur_mask & {NPORT{miso}}) : '0;

  // R1: never two go-ahead lines low together
  p_gnt_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));
  // R3: a seen release frees the bus on the next edge
  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rel_evt |=> (&gnt_n));
  // R4: a timeout hangs up and flags the port that held the grant
  p_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    to_hit |=> ((&gnt_n) && to_flag[$past(cur)]));
  // R5: abort hangs up without touching the flags
  p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> ((&gnt_n) && (to_flag == $past(to_flag))));
  // R6: only ports seen high since their last grant can win
  p_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_evt |-> armed[pick]);
endmodule

// File: tb/sim_spi_arb_hub.sv
`timescale 1ns/1ps
module sim_spi_arb_hub;
  localparam int N = 4;
  localparam int TW = 16;
  localparam realtime HALF = 40ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] grant_limit = 16'd1000;
  logic          abort = 1'b0;
  logic [N-1:0]  req_n = '1, sck = '0, copi = '0;
  logic [N-1:0]  cipo, gnt_n, to_flag;
  logic [7:0]    tx_data, rx_data;
  logic          tx_take, rx_valid;
  logic [1:0]    rx_port;

  int nchk = 0, nfail = 0;
  int k = 0, rx_cnt = 0;
  logic kclr = 1'b0;
  logic [7:0] rx_log [0:15];
  logic [1:0] rxp_log [0:15];

  always #2.5 clk = ~clk;

  spi_arb_hub #(.NPORT(N), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .grant_limit(grant_limit), .abort(abort),
    .req_n(req_n), .sck(sck), .copi(copi), .cipo(cipo), .gnt_n(gnt_n),
    .to_flag(to_flag), .tx_data(tx_data), .tx_take(tx_take),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_port(rx_port));

  // core side model: reply byte j of a transfer is 0x3C + 17*j
  assign tx_data = 8'h3C + 8'(17 * k);

  always @(posedge clk) begin
    if (kclr) begin
      k <= 0;
      rx_cnt <= 0;
    end else begin
      if (tx_take) k <= k + 1;
      if (rx_valid && rx_cnt < 16) begin
        rx_log[rx_cnt]  <= rx_data;
        rxp_log[rx_cnt] <= rx_port;
        rx_cnt <= rx_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_low(input int p, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (!gnt_n[p]) begin ok = 1'b1; break; end
      step(1);
    end
  endtask

  function automatic int rr_expect(input logic [N-1:0] pend, input int last);
    for (int off = 1; off <= N; off++) begin
      int idx;
      idx = (last + off) % N;
      if (pend[idx]) return idx;
    end
    return -1;
  endfunction

  task automatic xfer(input int p, input int nb);
    bit ok;
    logic [7:0] b, got;
    step(1); kclr = 1'b1; step(1); kclr = 1'b0;
    req_n[p] = 1'b0;
    wait_low(p, ok);
    chk(ok, "R1 grant for transfer", gnt_n, p);
    for (int j = 0; j < nb; j++) begin
      b = 8'hC3 ^ 8'(p * 16) ^ 8'(j);
      for (int i = 7; i >= 0; i--) begin
        copi[p] = b[i];
        #(HALF);
        got[i] = cipo[p];
        chk((cipo & ~(4'b1 << p)) == 0, "R9 idle port cipo", cipo, 0);
        sck[p] = 1'b1;
        #(HALF);
        sck[p] = 1'b0;
      end
      chk(got == 8'h3C + 8'(17 * j), "R8 reply byte", got, 8'h3C + 8'(17 * j));
    end
    #(HALF);
    @(negedge clk);
    chk(gnt_n[p] == 1'b0, "R3 go-ahead held at end", gnt_n, 0);
    req_n[p] = 1'b1;
    step(2);
    chk(gnt_n[p] == 1'b0, "R3 still low two edges after release", gnt_n[p], 0);
    step(1);
    chk(gnt_n == 4'hF, "R3 released on third edge", gnt_n, 4'hF);
    chk(rx_cnt == nb, "R7 byte count", rx_cnt, nb);
    for (int j = 0; j < nb; j++) begin
      b = 8'hC3 ^ 8'(p * 16) ^ 8'(j);
      chk(rx_log[j] == b, "R7 received byte", rx_log[j], b);
      chk(rxp_log[j] == 2'(p), "R7 received port", rxp_log[j], p);
    end
  endtask

  initial begin : watchdog
    #(500us);
    nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin : main
    bit ok;
    int last, cnt, e;
    logic [N-1:0] pend;
    step(3);
    // R10 reset state
    chk(gnt_n == 4'hF, "R10 go-ahead idle", gnt_n, 4'hF);
    chk(cipo == 0 && to_flag == 0, "R10 cipo and flags", {cipo, to_flag}, 0);
    chk(!rx_valid && !tx_take, "R10 strobes", {rx_valid, tx_take}, 0);
    rst_n = 1'b1;
    step(3);

    // R1 grant latency from idle
    @(negedge clk); req_n[2] = 1'b0;
    step(2);
    chk(gnt_n == 4'hF, "R1 not yet granted", gnt_n, 4'hF);
    step(1);
    chk(gnt_n == 4'b1011, "R1 granted on third edge", gnt_n, 4'b1011);
    req_n[2] = 1'b1;
    step(5);
    last = 2;

    // R2 round-robin sweep over every request mask
    for (int m = 1; m < 16; m++) begin
      pend = 4'(m);
      @(negedge clk); req_n = ~pend;
      while (pend != 0) begin
        for (int i = 0; i < 20 && gnt_n == 4'hF; i++) step(1);
        e = rr_expect(pend, last);
        chk(gnt_n == ~(4'b1 << e), "R2 round-robin pick", gnt_n, ~(4'b1 << e));
        if (gnt_n != ~(4'b1 << e)) begin req_n = '1; step(10); break; end
        req_n[e] = 1'b1;
        pend[e] = 1'b0;
        last = e;
        step(4);
      end
      step(4);
    end

    // R7 R8 R9 R3 data transfers on two ports
    xfer(1, 3);
    xfer(3, 2);
    last = 3;

    // R4 timeout length and flag, R6 no re-grant while held
    grant_limit = 16'd20;
    @(negedge clk); req_n[1] = 1'b0;
    wait_low(1, ok);
    cnt = 0;
    for (int i = 0; i < 100 && !gnt_n[1]; i++) begin cnt++; step(1); end
    chk(cnt == 21, "R4 go-ahead low cycles", cnt, 21);
    chk(to_flag == 4'b0010, "R4 timeout flag set", to_flag, 4'b0010);
    cnt = 0;
    for (int i = 0; i < 30; i++) begin if (!gnt_n[1]) cnt++; step(1); end
    chk(cnt == 0, "R6 no re-grant while request held", cnt, 0);
    req_n[1] = 1'b1;
    step(4);
    chk(to_flag == 4'b0010, "R4 flag kept after release", to_flag, 4'b0010);
    grant_limit = 16'd1000;
    req_n[1] = 1'b0;
    wait_low(1, ok);
    chk(ok, "R6 re-grant after high seen", gnt_n, 4'b1101);
    step(1);
    chk(to_flag == 0, "R4 flag cleared by new grant", to_flag, 0);
    req_n[1] = 1'b1;
    step(5);

    // R5 abort hangs up without a flag
    req_n[3] = 1'b0;
    wait_low(3, ok);
    step(2);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk(gnt_n == 4'hF, "R5 abort releases go-ahead", gnt_n, 4'hF);
    chk(to_flag == 0, "R5 abort leaves flags", to_flag, 0);
    cnt = 0;
    for (int i = 0; i < 15; i++) begin if (!gnt_n[3]) cnt++; step(1); end
    chk(cnt == 0, "R6 no re-grant after abort", cnt, 0);
    req_n[3] = 1'b1;
    step(5);
    chk(cipo == 0, "R9 cipo idle at end", cipo, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule